// File: doc/BRIEF.md
# Eight-bit ALU with flag generation

This block is the arithmetic and logic stage of an 8-bit accumulator processor. It is purely combinational. It takes the accumulator value, a second operand, the current flag byte and a 4-bit operation code. In the same cycle it returns the new accumulator value and the new flag byte. The surrounding datapath decides whether to write these back.

The block covers ten operations:

- add, and add with carry
- subtract, and subtract with borrow
- compare
- AND, XOR, OR
- increment and decrement of the accumulator

The flag byte it produces matches a classic 8-bit processor bit for bit:

- Two undocumented bits copy result bits 5 and 3.
- One flag serves as parity for logic operations and as signed overflow for arithmetic.
- Compare takes its copy bits from the operand.

Op codes that are not assigned pass the accumulator and flag byte through untouched.

Top module: `alu8_flag_unit`

## Requirements
- R1: Flag byte layout is bit 7 sign, bit 6 zero, bit 5 copy of result bit 5, bit 4 half-carry, bit 3 copy of result bit 3, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. For every assigned op except compare, sign, zero and both copy bits are taken from the 8-bit result.
- R2: Op 0 (add) returns acc+opnd and op 1 (add with carry) returns acc+opnd+flags_i[0]. The carry flag is bit 8 of the 9-bit sum, and the subtract flag is cleared.
- R3: Op 2 (subtract) returns acc-opnd and op 3 (subtract with borrow) returns acc-opnd-flags_i[0]. The carry flag is the borrow out of bit 7, and the subtract flag is set.
- R4: Half-carry for arithmetic ops is bit 4 of (acc XOR operand XOR 9-bit result). For increment and decrement the operand is taken as 1.
- R5: For additions, overflow is set when both operands share a sign and the result sign differs. For subtractions, overflow is set when the operands differ in sign and the result sign differs from the accumulator.
- R6: Op 7 (compare) returns the accumulator unchanged. Its flags are those of a subtract, except that bits 5 and 3 copy operand bits 5 and 3.
- R7: Op 4 is AND, op 5 is XOR and op 6 is OR. Half-carry is 1 for AND and 0 for XOR and OR. Carry and subtract are 0. Parity/overflow is 1 when the result has an even number of ones.
- R8: Op 8 (increment) returns acc+1 and op 9 (decrement) returns acc-1. The operand input is ignored and the carry flag is copied from flags_i[0]. Overflow is set only for a result of 0x80 (increment) or 0x7F (decrement). The subtract flag is set by decrement only.
- R9: Op codes 10 to 15 return acc_i and flags_i unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flag byte; bit 0 is the incoming carry |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | New accumulator value |
| flags_o | output | 8 | New flag byte |

## Verification
The hardest cases are where the flag rules depart from the plain result. These are:

- overflow at the exact 0x7F/0x80 boundary, where the incoming carry tips a sum over;
- compare's copy bits, where the operand's bits 5 and 3 differ from those of the difference;
- increment and decrement, which must hold a carry that the arithmetic would otherwise change.

The stimulus reaches all of them by sweeping every op code, including the unassigned ones, over all 256×256 input pairs with both carry values. The incoming flag byte varies with the operand. Hand-computed corner vectors name each boundary directly.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int OPW = 4;
  localparam int HB  = DW / 2;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_Y  = 5;
  localparam int FB_H  = 4;
  localparam int FB_X  = 3;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  function automatic logic [DW-1:0] pack_flags(
    input logic s, input logic z, input logic y, input logic h,
    input logic x, input logic pv, input logic n, input logic c);
    logic [DW-1:0] f;
    f = '0;
    f[FB_S] = s;  f[FB_Z] = z;  f[FB_Y] = y;   f[FB_H] = h;
    f[FB_X] = x;  f[FB_PV] = pv; f[FB_N] = n;  f[FB_C] = c;
    return f;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         half_o,
  output logic         ovf_o
);
  logic [W:0]   wide;
  logic [W:0]   cin_w;
  logic [W-1:0] mix;

  always_comb begin
    cin_w = {{W{1'b0}}, cin_i};
    if (sub_i) wide = {1'b0, a_i} - {1'b0, b_i} - cin_w;
    else       wide = {1'b0, a_i} + {1'b0, b_i} + cin_w;
  end

  assign res_o  = wide[W-1:0];
  assign cout_o = wide[W];
  assign mix    = a_i ^ b_i ^ wide[W-1:0];
  assign half_o = mix[HB];

  always_comb begin
    if (sub_i) ovf_o = (a_i[W-1] ^ b_i[W-1]) & (wide[W-1] ^ a_i[W-1]);
    else       ovf_o = ~(a_i[W-1] ^ b_i[W-1]) & (wide[W-1] ^ a_i[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o,
  output logic         even_o
);
  logic [W:0] pchain;

  always_comb begin
    case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
  end

  assign pchain[0] = 1'b0;
  for (genvar gi = 0; gi < W; gi++) begin : g_par
    assign pchain[gi+1] = pchain[gi] ^ res_o[gi];
  end
  assign even_o = ~pchain[W];
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
  import alu8_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  input  logic [3:0] op_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o
);
  localparam int W = DW;

  logic         is_sub, is_step, use_cin, is_arith, is_logic;
  logic [W-1:0] b_eff;
  logic         cin_eff;
  logic [W-1:0] ar_res;
  logic         ar_cout, ar_half, ar_ovf;
  logic [1:0]   lg_sel;
  logic [W-1:0] lg_res;
  logic         lg_even;

  always_comb begin
    is_sub   = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP) || (op_i == OP_DEC);
    is_step  = (op_i == OP_INC) || (op_i == OP_DEC);
    use_cin  = (op_i == OP_ADC) || (op_i == OP_SBC);
    is_arith = (op_i == OP_ADD) || (op_i == OP_ADC) || (op_i == OP_SUB) ||
               (op_i == OP_SBC) || is_step;
    is_logic = (op_i == OP_AND) || (op_i == OP_XOR) || (op_i == OP_OR);
    b_eff    = is_step ? W'(1) : opnd_i;
    cin_eff  = use_cin & flags_i[FB_C];
    case (op_i)
      OP_AND:  lg_sel = 2'd0;
      OP_XOR:  lg_sel = 2'd1;
      default: lg_sel = 2'd2;
    endcase
  end

  alu8_arith #(.W(W), .HB(HB)) u_arith (
    .a_i(acc_i), .b_i(b_eff), .cin_i(cin_eff), .sub_i(is_sub),
    .res_o(ar_res), .cout_o(ar_cout), .half_o(ar_half), .ovf_o(ar_ovf)
  );

  alu8_logic #(.W(W)) u_logic (
    .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel),
    .res_o(lg_res), .even_o(lg_even)
  );

  always_comb begin
    result_o = acc_i;
    flags_o  = flags_i;
    if (is_arith) begin
      result_o = ar_res;
      flags_o  = pack_flags(ar_res[W-1], ar_res == '0, ar_res[5], ar_half,
                            ar_res[3], ar_ovf, is_sub,
                            is_step ? flags_i[FB_C] : ar_cout);
    end else if (op_i == OP_CMP) begin
      result_o = acc_i;
      flags_o  = pack_flags(ar_res[W-1], ar_res == '0, opnd_i[5], ar_half,
                            opnd_i[3], ar_ovf, 1'b1, ar_cout);
    end else if (is_logic) begin
      result_o = lg_res;
      flags_o  = pack_flags(lg_res[W-1], lg_res == '0, lg_res[5],
                            op_i == OP_AND, lg_res[3], lg_even, 1'b0, 1'b0);
    end
  end

  // Port-level checks, one per requirement they guard
  always_comb begin
    if (op_i <= 4'd9 && op_i != OP_CMP)
      a_r1_zero_tracks_result: assert (flags_o[FB_Z] == (result_o == 8'h00));
    if (op_i == OP_CMP)
      a_r6_cmp_keeps_acc: assert (result_o == acc_i && flags_o[FB_N] &&
                                  flags_o[FB_Y] == opnd_i[5] && flags_o[FB_X] == opnd_i[3]);
    if (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR)
      a_r7_logic_flags: assert (!flags_o[FB_N] && !flags_o[FB_C] &&
                                flags_o[FB_PV] == ~(^result_o));
    if (op_i == OP_INC || op_i == OP_DEC)
      a_r8_keep_carry: assert (flags_o[FB_C] == flags_i[FB_C]);
    if (op_i > 4'd9)
      a_r9_passthru: assert (result_o == acc_i && flags_o == flags_i);
  end
endmodule

// File: tb/sim_alu8_flag_unit.sv
module sim_alu8_flag_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] acc, opnd, fin;
  logic [3:0] op;
  logic [7:0] res, fout;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  alu8_flag_unit u0 (
    .acc_i(acc), .opnd_i(opnd), .flags_i(fin), .op_i(op),
    .result_o(res), .flags_o(fout)
  );

  function automatic logic [15:0] model(int o, int a, int b, logic [7:0] fi);
    int c, cc, r, sa, sb, sv, ones;
    logic [7:0] rv, yx;
    logic h, v, cy, n;
    c  = int'(fi[0]);
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    h = 0; v = 0; cy = 0; n = 0; r = a;
    case (o)
      0, 1: begin
        cc = (o == 1) ? c : 0;
        r = a + b + cc; cy = r > 255;
        h = ((a & 15) + (b & 15) + cc) > 15;
        sv = sa + sb + cc; v = (sv > 127) || (sv < -128);
      end
      2, 3, 7: begin
        cc = (o == 3) ? c : 0;
        r = a - b - cc; cy = r < 0;
        h = ((a & 15) - (b & 15) - cc) < 0;
        sv = sa - sb - cc; v = (sv > 127) || (sv < -128); n = 1;
      end
      4, 5, 6: begin
        r = (o == 4) ? (a & b) : (o == 5) ? (a ^ b) : (a | b);
        ones = 0;
        for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
        v = (ones % 2) == 0; h = (o == 4);
      end
      8: begin r = a + 1; h = (a & 15) == 15; v = (a == 127); cy = fi[0]; end
      9: begin r = a - 1; h = (a & 15) == 0;  v = (a == 128); cy = fi[0]; n = 1; end
      default: return {a[7:0], fi};
    endcase
    rv = r[7:0];
    yx = (o == 7) ? b[7:0] : rv;
    return {(o == 7) ? a[7:0] : rv,
            rv[7], rv == 8'h00, yx[5], h, yx[3], v, n, cy};
  endfunction

  function automatic string tag(int o);
    case (o)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5, 6: return "R7";
      7:       return "R6";
      8, 9:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic directed(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] fi, input logic [7:0] er, input logic [7:0] ef,
                          input string t);
    op = o; acc = a; opnd = b; fin = fi;
    #1;
    checks++;
    if (res !== er || fout !== ef) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h: got %h/%h expected %h/%h", t, o, a, b, res, fout, er, ef);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    op = 4'd0; acc = 8'h00; opnd = 8'h00; fin = 8'h00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: zero result of an add sets only Z
    directed(4'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40, "R1");
    // R1: sign and copy bits from an OR result with odd parity
    directed(4'd6, 8'hA8, 8'h00, 8'h00, 8'hA8, 8'hA8, "R1");
    // R4: low-nibble carry
    directed(4'd0, 8'h0F, 8'h01, 8'h00, 8'h10, 8'h10, "R4");
    // R5: positive + positive gives negative
    directed(4'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h94, "R5");
    // R5: negative - positive gives positive
    directed(4'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h3E, "R5");
    // R2: carry-in wraps 0xFF to zero
    directed(4'd1, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h51, "R2");
    // R6: copy bits come from operand 0x28
    directed(4'd7, 8'h00, 8'h28, 8'h00, 8'h00, 8'hBB, "R6");
    // R8: increment to 0x80 keeps carry, ignores operand
    directed(4'd8, 8'h7F, 8'h55, 8'h01, 8'h80, 8'h95, "R8");
    // R8: decrement to 0x7F
    directed(4'd9, 8'h80, 8'hAA, 8'h00, 8'h7F, 8'h3E, "R8");
    // R9: unassigned code passes through
    directed(4'd12, 8'h3C, 8'h99, 8'hC3, 8'h3C, 8'hC3, "R9");

    for (int o = 0; o < 16; o++) begin
      for (int a = 0; a < 256; a++) begin
        logic [15:0] first_got, first_exp;
        int bad_b;
        bit bad;
        bad = 1'b0; bad_b = 0; first_got = '0; first_exp = '0;
        for (int b = 0; b < 256; b++) begin
          for (int c = 0; c < 2; c++) begin
            logic [7:0] fi;
            logic [15:0] e;
            fi = {b[6:0] ^ 7'h2D, c[0]};
            op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; fin = fi;
            #1;
            e = model(o, a, b, fi);
            if (!bad && {res, fout} !== e) begin
              bad = 1'b1; bad_b = b * 2 + c; first_got = {res, fout}; first_exp = e;
            end
          end
        end
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s op=%0d a=%h b=%h cin=%0d: got %h expected %h",
                   tag(o), o, a[7:0], bad_b / 2, bad_b % 2, first_got, first_exp);
        end
      end
    end
    finish_run();
  end
endmodule